// File: doc/BRIEF.md
# Stop-Bit Issue Group Sequencer

The sequencer takes in a stream of fixed bundles, three syllables per bundle. Each syllable has its own stop flag. The sequencer cuts the stream into parallel groups and hands each group to a back end that is `LANES` wide. A syllable whose stop flag is set is the last syllable of its group, and the next syllable opens a new group. A group can run across several bundles. When a group is wider than the back end, it leaves over several cycles, `LANES` syllables at a time, in program order. Syllables of two different groups never share an issue cycle.

As each group leaves, the block checks it for register hazards inside the group. A syllable must not write a register that another syllable of the same group reads. Two syllables of the same group must not write the same register. Register 0 is a constant and is never checked. The group length that the scan tracks has a limit, and a group longer than that limit raises an overflow flag. Upstream feeds bundles through a valid/ready pair. Downstream receives per-lane valid bits, the register and opcode fields of each lane, a group-end marker and three error pulses, all in the same cycle.

Top module: `stopbit_group_seq`

## Requirements
- R1: After reset, `in_ready` is 1, no lane is valid and all error outputs are 0. A bundle is taken at a rising clock edge where `in_valid` and `in_ready` are both 1.
- R2: In `in_syl`, slot k sits at bits [k*26 +: 26] and holds {opcode[7:0], dst[5:0], src_a[5:0], src_b[5:0]}, MSB first. Its stop flag is `in_stop[k]`. Slot 0 comes first in program order. Each issue cycle fills lanes from lane 0 upward, so lane 0 carries the oldest syllable. The valid lanes always form a contiguous run that starts at lane 0.
- R3: A syllable with its stop flag set is the last valid lane of its issue cycle, and `grp_end` is 1 in that cycle. No syllable after it issues in the same cycle.
- R4: A group of w syllables issues over ceil(w/LANES) cycles. Every cycle except the last carries LANES syllables. In the last cycle the unused upper lanes are invalid and `grp_end` is 1.
- R5: If fewer than LANES syllables are buffered and none of them has a stop flag, nothing issues until more syllables arrive.
- R6: `err_raw` pulses in the issue cycle of a syllable in either of two cases. The syllable reads a register that an earlier syllable of its group writes. Or the syllable writes a register that an earlier syllable of its group reads.
- R7: `err_waw` pulses in the issue cycle of a syllable that writes a register already written earlier in its group.
- R8: Register 0 never causes `err_raw` or `err_waw`.
- R9: Hazard tracking starts empty for every group, so the same registers used across two groups raise no flag.
- R10: `err_ovf` pulses in the issue cycle holding the syllable whose position in its group is greater than MAX_GRP (default 8).
- R11: `in_ready` is 0 whenever the buffer holds more than DEPTH-3 syllables (default DEPTH 6).
- R12: A syllable taken at an edge can issue in the cycle that directly follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A bundle is offered |
| in_ready | output | 1 | The buffer can take a bundle |
| in_syl | input | 3*26 | Three syllables, slot 0 in the low bits |
| in_stop | input | 3 | Stop flag for each slot |
| lane_valid | output | LANES | Valid flag for each lane |
| lane_op | output | LANES*8 | Opcode of each lane |
| lane_dst | output | LANES*6 | Destination register of each lane |
| lane_src_a | output | LANES*6 | First source register of each lane |
| lane_src_b | output | LANES*6 | Second source register of each lane |
| grp_end | output | 1 | This cycle ends a group |
| err_raw | output | 1 | Read-after-write conflict inside the group |
| err_waw | output | 1 | Write-after-write conflict inside the group |
| err_ovf | output | 1 | Group longer than MAX_GRP |

## Verification
The assertions check the cycle-level structure on every cycle:
- the valid lanes are packed from lane 0 upward;
- `grp_end` and the error pulses appear only in cycles that issue;
- the buffer never holds more than its depth;
- an accepted bundle always issues something in the next cycle.

Three things depend on the register numbers, stop patterns and timing of whole sequences, so only the bench's directed scenarios can show them:
- which syllables land in which cycle;
- the hazard and overflow flags being raised or not, including the register-0 exemption and the clearing of tracking between groups;
- the stall while a group waits for its next bundle.

// File: rtl/sgs_pkg.sv
// Shared widths and the buffered syllable record for the group sequencer.
// Assumes three syllables per bundle and a 64-entry register space.
package sgs_pkg;
    parameter int REG_W = 6;
    parameter int OP_W  = 8;
    parameter int SLOTS = 3;
    localparam int SYL_W = OP_W + 3 * REG_W;

    typedef struct packed {
        logic             stop;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] sa;
        logic [REG_W-1:0] sb;
    } syl_t;
endpackage

// File: rtl/sgs_syl_buf.sv
// Circular syllable buffer. It takes a whole bundle at once and releases
// 0..LANES syllables per cycle from the head.
// Assumes the caller pushes only when DEPTH-occ >= SLOTS and never pops more than occ.
module sgs_syl_buf
    import sgs_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int LANES = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  syl_t [SLOTS-1:0]        push_syl,
    input  logic [CNT_W-1:0]        pop_cnt,
    output syl_t [LANES-1:0]        peek,
    output logic [CNT_W-1:0]        occ
);
    syl_t             mem [DEPTH];
    logic [PTR_W-1:0] head, tail;

    // Storage write: place the three slots of a bundle at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            for (int k = 0; k < SLOTS; k++) begin
                mem[PTR_W'((int'(tail) + k) % DEPTH)] <= push_syl[k];
            end
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= PTR_W'((int'(tail) + SLOTS) % DEPTH);
            head <= PTR_W'((int'(head) + int'(pop_cnt)) % DEPTH);
            occ  <= CNT_W'(int'(occ) + (push ? SLOTS : 0) - int'(pop_cnt));
        end
    end

    // Head window: the next LANES syllables in program order.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            peek[i] = mem[PTR_W'((int'(head) + i) % DEPTH)];
        end
    end
endmodule

// File: rtl/sgs_lane_pick.sv
// Chooses how many head syllables issue this cycle. It stops after the first
// stop flag and never takes more than LANES. It waits while a group is still
// incomplete and fewer than LANES syllables are buffered.
// Assumes LANES <= DEPTH.
module sgs_lane_pick #(
    parameter int LANES = 2,
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [LANES-1:0] head_stop,
    input  logic [CNT_W-1:0] occ,
    output logic [LANES-1:0] take,
    output logic [CNT_W-1:0] take_cnt,
    output logic             grp_end
);
    logic found;
    logic fire;
    int   n;

    // Scan the head window for the end of the group and decide whether to fire.
    always_comb begin
        found = 1'b0;
        n     = 0;
        for (int i = 0; i < LANES; i++) begin
            if (!found && i < int'(occ)) begin
                n = i + 1;
                if (head_stop[i]) found = 1'b1;
            end
        end
        fire     = found || (int'(occ) >= LANES);
        take_cnt = fire ? CNT_W'(n) : '0;
        grp_end  = fire && found;
        take     = '0;
        for (int i = 0; i < LANES; i++) begin
            if (fire && i < n) take[i] = 1'b1;
        end
    end
endmodule

// File: rtl/sgs_hazard_scan.sv
// Intra-group hazard scanner. It keeps read and write register masks plus a
// length count for the open group. It checks the lanes issuing this cycle in
// lane order and clears all state when the group ends. Register 0 is skipped.
// Assumes take is a contiguous run from lane 0.
module sgs_hazard_scan
    import sgs_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int MAX_GRP = 8,
    localparam int NREG  = 1 << REG_W,
    localparam int GCW   = $clog2(MAX_GRP + 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            take,
    input  logic                        grp_end,
    input  logic [LANES-1:0][REG_W-1:0] h_dst,
    input  logic [LANES-1:0][REG_W-1:0] h_sa,
    input  logic [LANES-1:0][REG_W-1:0] h_sb,
    output logic                        err_raw,
    output logic                        err_waw,
    output logic                        err_ovf
);
    logic [NREG-1:0] wr_q, rd_q, wr_c, rd_c;
    logic [GCW-1:0]  cnt_q;
    int              idx;

    // Lane-ordered check against the masks accumulated so far in the group.
    always_comb begin
        wr_c    = wr_q;
        rd_c    = rd_q;
        idx     = int'(cnt_q);
        err_raw = 1'b0;
        err_waw = 1'b0;
        err_ovf = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (take[i]) begin
                idx = idx + 1;
                if (idx > MAX_GRP) err_ovf = 1'b1;
                if (h_sa[i] != '0 && wr_c[h_sa[i]]) err_raw = 1'b1;
                if (h_sb[i] != '0 && wr_c[h_sb[i]]) err_raw = 1'b1;
                if (h_dst[i] != '0 && rd_c[h_dst[i]]) err_raw = 1'b1;
                if (h_dst[i] != '0 && wr_c[h_dst[i]]) err_waw = 1'b1;
                if (h_sa[i] != '0) rd_c[h_sa[i]] = 1'b1;
                if (h_sb[i] != '0) rd_c[h_sb[i]] = 1'b1;
                if (h_dst[i] != '0) wr_c[h_dst[i]] = 1'b1;
            end
        end
    end

    // Carry the masks and count across cycles; reset them at each group end.
    always_ff @(posedge clk) begin
        if (!rst_n || grp_end) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (|take) begin
            wr_q  <= wr_c;
            rd_q  <= rd_c;
            cnt_q <= (idx > MAX_GRP) ? GCW'(MAX_GRP + 1) : GCW'(idx);
        end
    end
endmodule

// File: rtl/stopbit_group_seq.sv
// Top of the stop-bit issue group sequencer. A valid/ready bundle port feeds
// a syllable buffer, the picker forms each issue cycle, and the hazard scanner
// flags conflicts inside a group. The lane outputs are combinational from the
// buffer head.
// Assumes LANES <= 3 and DEPTH >= SLOTS + 2, so a waiting group can always take
// its next bundle.
module stopbit_group_seq
    import sgs_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int DEPTH   = 6,
    parameter int MAX_GRP = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [SLOTS*SYL_W-1:0]  in_syl,
    input  logic [SLOTS-1:0]        in_stop,
    output logic [LANES-1:0]        lane_valid,
    output logic [LANES*OP_W-1:0]   lane_op,
    output logic [LANES*REG_W-1:0]  lane_dst,
    output logic [LANES*REG_W-1:0]  lane_src_a,
    output logic [LANES*REG_W-1:0]  lane_src_b,
    output logic                    grp_end,
    output logic                    err_raw,
    output logic                    err_waw,
    output logic                    err_ovf
);
    syl_t [SLOTS-1:0]        push_syl;
    syl_t [LANES-1:0]        peek;
    logic [CNT_W-1:0]        occ;
    logic [CNT_W-1:0]        take_cnt;
    logic [LANES-1:0]        take;
    logic [LANES-1:0]        head_stop;
    logic [LANES-1:0][REG_W-1:0] h_dst, h_sa, h_sb;
    logic                    push;

    // Room for one more whole bundle decides readiness.
    assign in_ready = int'(occ) <= DEPTH - SLOTS;
    assign push     = in_valid && in_ready;

    // Unpack the flat bundle into syllable records.
    for (genvar k = 0; k < SLOTS; k++) begin : g_unpack
        assign push_syl[k] = {in_stop[k], in_syl[k*SYL_W +: SYL_W]};
    end

    // Fan the head window out to lanes and the hazard scanner.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign head_stop[i]                   = peek[i].stop;
        assign h_dst[i]                       = peek[i].dst;
        assign h_sa[i]                        = peek[i].sa;
        assign h_sb[i]                        = peek[i].sb;
        assign lane_valid[i]                  = take[i];
        assign lane_op[i*OP_W +: OP_W]        = peek[i].op;
        assign lane_dst[i*REG_W +: REG_W]     = peek[i].dst;
        assign lane_src_a[i*REG_W +: REG_W]   = peek[i].sa;
        assign lane_src_b[i*REG_W +: REG_W]   = peek[i].sb;
    end

    sgs_syl_buf #(.DEPTH(DEPTH), .LANES(LANES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_syl (push_syl),
        .pop_cnt  (take_cnt),
        .peek     (peek),
        .occ      (occ)
    );

    sgs_lane_pick #(.LANES(LANES), .DEPTH(DEPTH)) u_pick (
        .head_stop (head_stop),
        .occ       (occ),
        .take      (take),
        .take_cnt  (take_cnt),
        .grp_end   (grp_end)
    );

    sgs_hazard_scan #(.LANES(LANES), .MAX_GRP(MAX_GRP)) u_haz (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .grp_end (grp_end),
        .h_dst   (h_dst),
        .h_sa    (h_sa),
        .h_sb    (h_sb),
        .err_raw (err_raw),
        .err_waw (err_waw),
        .err_ovf (err_ovf)
    );
endmodule

// File: rtl/sgs_chk.sv
// Protocol checker for the group sequencer, attached through bind.
// Assumes LANES <= 3, so an accepted bundle always fires the next cycle.
module sgs_chk #(
    parameter int LANES = 2,
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [CNT_W-1:0] occ,
    input logic [LANES-1:0] lane_valid,
    input logic             grp_end,
    input logic             err_raw,
    input logic             err_waw,
    input logic             err_ovf
);
    a_r2_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
        (LANES'(lane_valid + LANES'(1)) & lane_valid) == '0);

    a_r3_end_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end |-> lane_valid[0]);

    a_r6_raw_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
        err_raw |-> lane_valid[0]);

    a_r7_waw_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
        err_waw |-> lane_valid[0]);

    a_r10_ovf_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |-> lane_valid[0]);

    a_r11_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    a_r12_issue_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> lane_valid[0]);
endmodule

bind stopbit_group_seq sgs_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .occ        (occ),
    .lane_valid (lane_valid),
    .grp_end    (grp_end),
    .err_raw    (err_raw),
    .err_waw    (err_waw),
    .err_ovf    (err_ovf)
);

// File: tb/tb_stopbit_group_seq.sv
`timescale 1ns/1ps
module tb_stopbit_group_seq;
    localparam int LANES = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [77:0] in_syl = '0;
    logic [2:0]  in_stop = '0;
    logic [LANES-1:0]   lane_valid;
    logic [LANES*8-1:0] lane_op;
    logic [LANES*6-1:0] lane_dst, lane_src_a, lane_src_b;
    logic grp_end, err_raw, err_waw, err_ovf;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int ops [64];
    int nops = 0;
    int cn [32], ce [32], cr [32], cw [32], co [32];
    int ncyc = 0;

    stopbit_group_seq dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_syl(in_syl), .in_stop(in_stop), .lane_valid(lane_valid),
        .lane_op(lane_op), .lane_dst(lane_dst), .lane_src_a(lane_src_a),
        .lane_src_b(lane_src_b), .grp_end(grp_end), .err_raw(err_raw),
        .err_waw(err_waw), .err_ovf(err_ovf)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp<=20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Monitor: log every issue cycle away from the active edge.
    always @(negedge clk) begin
        if (rst_n && lane_valid[0]) begin
            for (int l = 0; l < LANES; l++)
                if (lane_valid[l]) begin ops[nops] = int'(lane_op[l*8 +: 8]); nops++; end
            cn[ncyc] = $countones(lane_valid);
            ce[ncyc] = int'(grp_end);
            cr[ncyc] = int'(err_raw);
            cw[ncyc] = int'(err_waw);
            co[ncyc] = int'(err_ovf);
            ncyc++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [25:0] mk(input int op, input int d, input int a, input int b);
        return {8'(op), 6'(d), 6'(a), 6'(b)};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_log();
        nops = 0;
        ncyc = 0;
    endtask

    // Offer one bundle from a negedge and return at the negedge after it is taken.
    task automatic push(input logic [25:0] s0, s1, s2, input logic [2:0] st);
        while (!in_ready) @(negedge clk);
        in_syl   = {s2, s1, s0};
        in_stop  = st;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk_ops(input string tag, input int first, input int cnt);
        chk(nops == cnt, tag, nops, cnt);
        for (int i = 0; i < cnt; i++) chk(ops[i] == first + i, tag, ops[i], first + i);
    endtask

    function automatic int sum_flags(input int sel);
        int s = 0;
        for (int i = 0; i < ncyc; i++)
            s += (sel == 0) ? cr[i] : (sel == 1) ? cw[i] : co[i];
        return s;
    endfunction

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        chk(lane_valid == '0, "R1 no lane after reset", int'(lane_valid), 0);
        chk({err_raw, err_waw, err_ovf} == 3'b000, "R1 flags after reset",
            int'({err_raw, err_waw, err_ovf}), 0);
    endtask

    task automatic t_basic();
        clr_log();
        push(mk(1, 8, 1, 2), mk(2, 9, 1, 2), mk(3, 10, 1, 2), 3'b100);
        chk(lane_valid == 2'b11, "R12 issue right after accept", int'(lane_valid), 3);
        chk(lane_op[7:0] == 8'd1, "R12 lane0 oldest", int'(lane_op[7:0]), 1);
        idle(4);
        chk_ops("R2 program order", 1, 3);
        chk(ncyc == 2, "R4 cycles for width 3", ncyc, 2);
        chk(cn[0] == 2 && ce[0] == 0, "R4 first full cycle", cn[0] * 10 + ce[0], 20);
        chk(cn[1] == 1 && ce[1] == 1, "R4 partial last cycle ends", cn[1] * 10 + ce[1], 11);
    endtask

    task automatic t_all_stops();
        clr_log();
        push(mk(4, 8, 1, 2), mk(5, 9, 1, 2), mk(6, 10, 1, 2), 3'b111);
        idle(5);
        chk_ops("R3 order", 4, 3);
        chk(ncyc == 3, "R3 one syllable per group", ncyc, 3);
        for (int i = 0; i < 3; i++)
            chk(cn[i] == 1 && ce[i] == 1, "R3 stop closes cycle", cn[i] * 10 + ce[i], 11);
    endtask

    task automatic t_span();
        clr_log();
        push(mk(10, 8, 1, 2), mk(11, 9, 1, 2), mk(12, 10, 1, 2), 3'b000);
        idle(3);
        chk(nops == 2, "R5 waits for rest of group", nops, 2);
        push(mk(13, 11, 1, 2), mk(14, 12, 1, 2), mk(15, 13, 1, 2), 3'b101);
        idle(4);
        chk_ops("R5 spanning order", 10, 6);
        chk(ncyc == 3, "R5 cycles", ncyc, 3);
        chk(ce[0] == 0 && ce[1] == 1 && ce[2] == 1, "R3 span group ends",
            ce[0] * 100 + ce[1] * 10 + ce[2], 11);
    endtask

    task automatic t_raw();
        clr_log();
        push(mk(20, 5, 1, 2), mk(21, 6, 5, 3), mk(22, 3, 1, 2), 3'b100);
        idle(4);
        chk(ncyc == 2, "R6 cycles", ncyc, 2);
        chk(cr[0] == 1, "R6 read of earlier write", cr[0], 1);
        chk(cr[1] == 1, "R6 write of earlier read", cr[1], 1);
        chk(sum_flags(1) == 0, "R6 no waw", sum_flags(1), 0);
    endtask

    task automatic t_waw();
        clr_log();
        push(mk(30, 9, 1, 2), mk(31, 10, 1, 2), mk(32, 9, 1, 2), 3'b100);
        idle(4);
        chk(cw[0] == 0, "R7 clean first cycle", cw[0], 0);
        chk(cw[1] == 1, "R7 double write flagged", cw[1], 1);
        chk(sum_flags(0) == 0, "R7 shared reads are fine", sum_flags(0), 0);
    endtask

    task automatic t_reg0();
        clr_log();
        push(mk(40, 0, 1, 2), mk(41, 4, 0, 0), mk(42, 0, 1, 2), 3'b100);
        idle(4);
        chk(ncyc == 2, "R8 cycles", ncyc, 2);
        chk(sum_flags(0) == 0, "R8 no raw on r0", sum_flags(0), 0);
        chk(sum_flags(1) == 0, "R8 no waw on r0", sum_flags(1), 0);
    endtask

    task automatic t_clear();
        clr_log();
        push(mk(50, 11, 1, 2), mk(51, 12, 11, 11), mk(52, 14, 1, 2), 3'b101);
        push(mk(53, 11, 12, 1), mk(54, 16, 1, 2), mk(55, 17, 1, 2), 3'b100);
        idle(5);
        chk_ops("R9 order", 50, 6);
        chk(ncyc == 4, "R9 cycles", ncyc, 4);
        chk(sum_flags(0) + sum_flags(1) == 0, "R9 no cross-group flags",
            sum_flags(0) + sum_flags(1), 0);
    endtask

    task automatic t_ovf();
        clr_log();
        push(mk(60, 20, 1, 2), mk(61, 21, 1, 2), mk(62, 22, 1, 2), 3'b000);
        push(mk(63, 23, 1, 2), mk(64, 24, 1, 2), mk(65, 25, 1, 2), 3'b000);
        push(mk(66, 26, 1, 2), mk(67, 27, 1, 2), mk(68, 28, 1, 2), 3'b100);
        idle(5);
        chk_ops("R10 order", 60, 9);
        chk(ncyc == 5, "R10 cycles", ncyc, 5);
        chk(co[4] == 1, "R10 ninth syllable overflows", co[4], 1);
        chk(sum_flags(2) == 1, "R10 only one overflow cycle", sum_flags(2), 1);
        chk(cn[4] == 1 && ce[4] == 1, "R4 last partial cycle", cn[4] * 10 + ce[4], 11);
    endtask

    task automatic t_ready();
        clr_log();
        push(mk(70, 30, 1, 2), mk(71, 31, 1, 2), mk(72, 32, 1, 2), 3'b000);
        push(mk(73, 33, 1, 2), mk(74, 34, 1, 2), mk(75, 35, 1, 2), 3'b100);
        chk(in_ready == 1'b0, "R11 ready low with four buffered", int'(in_ready), 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R11 ready back after drain", int'(in_ready), 1);
        idle(4);
        chk_ops("R11 order", 70, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_all_stops();
        t_span();
        t_raw();
        t_waw();
        t_reg0();
        t_clear();
        t_ovf();
        t_ready();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule